// File: doc/BRIEF.md
# Dual-Channel Event Performance Counter

This block watches a core's event bus and keeps two 32-bit tallies of whichever events software has picked. Each channel picks one line out of a 256-line event bus. It qualifies each cycle against the core's current privilege level, and then counts in one of two ways. In occurrence mode it counts each new assertion of the line. In stall mode it counts every cycle the line stays high. One master enable bit gates both channels at once.

Software reaches the block through a minimal register bus with three word locations. The control word sits at byte offset 0x0. Counter 0 sits at 0x4 and counter 1 at 0x8. Both counters can be rewritten at any time, for example cleared to zero before a measurement. A counter has no overflow signalling: it simply wraps. Reads are combinational from the registered state.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset the control word and both counters read as zero.
- R2: Control bit 0 is the master enable; while it is 0 neither counter advances, whatever the channel fields hold.
- R3: Control layout: channel 0 uses bit 2 (debug-hold flag, stored only), bits 4:3 (privilege enable) and bits 12:5 (event select). Channel 1 uses bit 13, bits 15:14 and bits 23:16 for the same fields. The count-style bit is bit 24 for channel 0 and bit 25 for channel 1. Every writable bit reads back as written.
- R4: The privilege enable value 0 never counts, 1 counts only while `priv_super` is 0, 2 counts only while `priv_super` is 1, and 3 counts at either level.
- R5: Setting one channel's privilege enable to 0 stops only that channel; the other channel keeps counting.
- R6: With the count-style bit at 0 (stall mode), a qualified channel adds one on every clock edge at which its selected event line is high.
- R7: With the count-style bit at 1 (occurrence mode), a qualified channel adds one only on an edge where the selected line is high and was low at the previous edge.
- R8: A counter at 0xFFFFFFFF that receives an increment becomes 0.
- R9: A bus write to 0x4 or 0x8 loads the counter on that edge. If an increment falls on the same edge, the written value wins.
- R10: Bit 1 and bits 31:26 of the control word always read as 0 and ignore writes, and the unmapped word at 0xC reads as 0.
- R11: The event select can reach any of the 256 event lines, and each channel follows only its own selected line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| priv_super | input | 1 | Core privilege level: 0 user, 1 supervisor |
| evt_in | input | 256 | Event lines from the core |

## Verification
Two cases are hard to reach from the ports. The first is the clash between a software counter write and an event increment on the same edge. The bench gets there by holding the selected line high in stall mode and issuing the write in that same cycle. It then confirms the loaded value, and one cycle later the value plus one. The second is the counter wrap, which would take billions of cycles to reach naturally. The bench instead preloads 0xFFFFFFFF through the bus and supplies a single event cycle. The select field is swept over all 256 lines with the two channels on mirrored lines in different modes. The privilege enable, privilege level and count style are swept in full.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int NUM_CH      = 2;
  localparam int EVT_SEL_W   = 8;
  localparam int DATA_W      = 32;
  localparam int CH_BASE     = 2;
  localparam int CH_STRIDE   = 11;
  localparam int STYLE_BASE  = 24;
  localparam int PWR_BIT     = 0;
  localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h03FF_FFFD;

  typedef struct packed {
    logic                 occ_mode;
    logic [EVT_SEL_W-1:0] sel;
    logic [1:0]           priv_en;
    logic                 dbg_hold;
  } chan_cfg_t;

  function automatic chan_cfg_t unpack_chan(input logic [DATA_W-1:0] w, input int ch);
    chan_cfg_t c;
    int b;
    b = CH_BASE + CH_STRIDE * ch;
    c.dbg_hold = w[b];
    c.priv_en  = w[b+1 +: 2];
    c.sel      = w[b+3 +: EVT_SEL_W];
    c.occ_mode = w[STYLE_BASE + ch];
    return c;
  endfunction

  function automatic logic mode_permits(input logic [1:0] priv_en, input logic priv_super);
    return priv_super ? priv_en[1] : priv_en[0];
  endfunction

  function automatic logic event_hit(input logic occ, input logic cur, input logic prv);
    return occ ? (cur & ~prv) : cur;
  endfunction
endpackage

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
  import pmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              pwr_on,
  output chan_cfg_t         cfg [NUM_CH]
);
  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wdata & CTRL_WMASK;
  end

  assign pwr_on = ctrl_q[PWR_BIT];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cfg
    assign cfg[g] = unpack_chan(ctrl_q, g);
  end
endmodule

// File: rtl/pmu_event_sel.sv
module pmu_event_sel
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 256,
  localparam int SEL_W  = $clog2(NUM_EVT)
) (
  input  logic [NUM_EVT-1:0] evt_now,
  input  logic [NUM_EVT-1:0] evt_prev,
  input  logic [SEL_W-1:0]   sel,
  input  logic [1:0]         priv_en,
  input  logic               occ_mode,
  input  logic               priv_super,
  input  logic               pwr_on,
  output logic               hit
);
  logic cur_lvl, prv_lvl, qualified;

  assign cur_lvl   = evt_now[sel];
  assign prv_lvl   = evt_prev[sel];
  assign qualified = pwr_on & mode_permits(priv_en, priv_super);
  assign hit       = qualified & event_hit(occ_mode, cur_lvl, prv_lvl);
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wdata,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (wr_en) cnt_q <= wdata;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [DATA_W-1:0]               bus_wdata,
  output logic [DATA_W-1:0]               bus_rdata,
  input  logic                            priv_super,
  input  logic [(1<<EVT_SEL_W)-1:0]       evt_in
);
  localparam int NUM_EVT = 1 << EVT_SEL_W;
  localparam int WORD_W  = ADDR_W - 2;

  logic [WORD_W-1:0] word_idx;
  logic              wr_ctrl;
  logic [NUM_CH-1:0] wr_cnt_vec;
  logic [NUM_CH-1:0] inc_vec;
  logic [DATA_W-1:0] ctrl_word;
  logic              pwr_on;
  chan_cfg_t         cfg [NUM_CH];
  logic [CNT_W-1:0]  cnt_q [NUM_CH];
  logic [NUM_EVT-1:0] evt_prev;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign wr_ctrl  = bus_wr && (word_idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) evt_prev <= '0;
    else        evt_prev <= evt_in;
  end

  pmu_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_ctrl),
    .wdata  (bus_wdata),
    .ctrl_q (ctrl_word),
    .pwr_on (pwr_on),
    .cfg    (cfg)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign wr_cnt_vec[g] = bus_wr && (word_idx == WORD_W'(g + 1));

    pmu_event_sel #(.NUM_EVT(NUM_EVT)) u_sel (
      .evt_now    (evt_in),
      .evt_prev   (evt_prev),
      .sel        (cfg[g].sel),
      .priv_en    (cfg[g].priv_en),
      .occ_mode   (cfg[g].occ_mode),
      .priv_super (priv_super),
      .pwr_on     (pwr_on),
      .hit        (inc_vec[g])
    );

    pmu_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_cnt_vec[g]),
      .wdata (bus_wdata[CNT_W-1:0]),
      .inc   (inc_vec[g]),
      .cnt_q (cnt_q[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (word_idx == '0) bus_rdata = ctrl_word;
    for (int i = 0; i < NUM_CH; i++)
      if (word_idx == WORD_W'(i + 1)) bus_rdata = DATA_W'(cnt_q[i]);
  end
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      ctrl,
  input logic [1:0]       inc,
  input logic [1:0]       wr_cnt,
  input logic [31:0]      wdata,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1
);
  AST_PWR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |-> inc == 2'b00); // R2

  AST_CH0_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[4:3] == 2'b00 |-> !inc[0]); // R5

  AST_CH1_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[15:14] == 2'b00 |-> !inc[1]); // R5

  AST_CNT0_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    inc[0] && !wr_cnt[0] |=> cnt0 == $past(cnt0) + 1'b1); // R8

  AST_CNT0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc[0] && !wr_cnt[0] |=> $stable(cnt0)); // R6

  AST_CNT1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc[1] && !wr_cnt[1] |=> $stable(cnt1)); // R6

  AST_WR_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt[1] |=> cnt1 == $past(wdata[CNT_W-1:0])); // R9

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[1] == 1'b0 && ctrl[31:26] == 6'd0); // R10
endmodule

bind perf_mon_unit pmu_checker #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ctrl   (ctrl_word),
  .inc    (inc_vec),
  .wr_cnt (wr_cnt_vec),
  .wdata  (bus_wdata),
  .cnt0   (cnt_q[0]),
  .cnt1   (cnt_q[1])
);

// File: tb/tb_perf_mon_unit.sv
module tb_perf_mon_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        priv_super = 1'b0;
  logic [255:0] evt_in = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  perf_mon_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .priv_super(priv_super), .evt_in(evt_in)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] mk_ctrl(input bit pwr,
      input logic [1:0] en0, input logic [7:0] s0, input bit o0,
      input logic [1:0] en1, input logic [7:0] s1, input bit o1);
    logic [31:0] w;
    w = '0;
    w[0] = pwr;
    w[4:3] = en0;  w[12:5] = s0;  w[24] = o0;
    w[15:14] = en1; w[23:16] = s1; w[25] = o1;
    return w;
  endfunction

  // expected count for a level sequence starting from a low line
  function automatic int model_count(input bit allowed, input bit occ, input logic [7:0] pat, input int len);
    int n;
    bit prv;
    n = 0; prv = 0;
    for (int k = 0; k < len; k++) begin
      if (allowed && pat[k] && (!occ || !prv)) n++;
      prv = pat[k];
    end
    return n;
  endfunction

  task automatic clear_counters();
    bus_write(4'h4, 32'd0);
    bus_write(4'h8, 32'd0);
  endtask

  initial begin
    logic [31:0] r;
    logic [7:0]  pat;
    string       tg;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    bus_read(4'h0, r); check("R1 ctrl", r, 32'd0);
    bus_read(4'h4, r); check("R1 cnt0", r, 32'd0);
    bus_read(4'h8, r); check("R1 cnt1", r, 32'd0);

    // R10: reserved bits and unmapped word
    bus_write(4'h0, 32'hFFFF_FFFF);
    bus_read(4'h0, r); check("R10 rsvd", r, 32'h03FF_FFFD);
    bus_read(4'hC, r); check("R10 unmapped", r, 32'd0);

    // R3: field readback
    bus_write(4'h0, 32'h0155_A2B5);
    bus_read(4'h0, r); check("R3 readback", r, 32'h0155_A2B5 & 32'h03FF_FFFD);

    // R11, R6, R7: select sweep, ch0 stall on s, ch1 occurrence on 255-s
    for (int s = 0; s < 256; s++) begin
      evt_in = '0;
      bus_write(4'h0, mk_ctrl(1, 2'd3, 8'(s), 0, 2'd3, 8'(255 - s), 1));
      clear_counters();
      pat = 8'b0000_1101; // 1,0,1,1,0 in time order
      for (int k = 0; k < 5; k++) begin
        evt_in = '0;
        evt_in[s] = 1'b1;
        evt_in[255 - s] = pat[k];
        @(negedge clk);
      end
      evt_in = '0;
      bus_read(4'h4, r); check($sformatf("R6 R11 stall sel=%0d", s), r, 32'd5);
      bus_read(4'h8, r); check($sformatf("R7 R11 occ sel=%0d", 255 - s), r, 32'd2);
    end

    // R4, R5, R6, R7: privilege enable x level x style on ch0; ch1 always on
    for (int en = 0; en < 4; en++)
      for (int pv = 0; pv < 2; pv++)
        for (int oc = 0; oc < 2; oc++) begin
          bit allowed;
          evt_in = '0;
          priv_super = pv[0];
          bus_write(4'h0, mk_ctrl(1, 2'(en), 8'd3, oc[0], 2'd3, 8'd3, 0));
          clear_counters();
          pat = 8'b0000_1011; // 1,1,0,1
          for (int k = 0; k < 4; k++) begin
            evt_in[3] = pat[k];
            @(negedge clk);
          end
          evt_in = '0;
          allowed = pv ? en[1] : en[0];
          tg = $sformatf("R4 R5 en=%0d priv=%0d occ=%0d", en, pv, oc);
          bus_read(4'h4, r); check(tg, r, 32'(model_count(allowed, oc[0], pat, 4)));
          bus_read(4'h8, r); check({"R5 other ch ", tg}, r, 32'(model_count(1, 0, pat, 4)));
        end
    priv_super = 1'b0;

    // R2: master enable off
    bus_write(4'h0, mk_ctrl(0, 2'd3, 8'd9, 0, 2'd3, 8'd9, 1));
    clear_counters();
    evt_in[9] = 1'b1;
    repeat (4) @(negedge clk);
    evt_in = '0;
    bus_read(4'h4, r); check("R2 cnt0 gated", r, 32'd0);
    bus_read(4'h8, r); check("R2 cnt1 gated", r, 32'd0);

    // R8: wrap
    bus_write(4'h0, mk_ctrl(1, 2'd3, 8'd200, 0, 2'd3, 8'd200, 0));
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_write(4'h8, 32'hFFFF_FFFE);
    evt_in[200] = 1'b1;
    @(negedge clk);
    evt_in = '0;
    bus_read(4'h4, r); check("R8 wrap cnt0", r, 32'd0);
    bus_read(4'h8, r); check("R8 near wrap cnt1", r, 32'hFFFF_FFFF);

    // R9: write wins over same-edge increment
    evt_in[200] = 1'b1;
    bus_write(4'h4, 32'h0000_1234);
    bus_read(4'h4, r); check("R9 write prio", r, 32'h0000_1234);
    @(negedge clk);
    evt_in = '0;
    bus_read(4'h4, r); check("R9 resume", r, 32'h0000_1235);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule